// File: doc/BRIEF.md
# Tone-Bit Clock Recovery and NRZI Decoder

This block sits behind a tone discriminator in an audio frequency-shift-keyed receiver. Each accepted sample carries one hard-decision tone bit, and eight samples make one data bit. The block keeps a fine phase counter that moves 8 steps per sample and completes a bit period every 64 steps. When a clean signal transition shows up in the recent samples, the counter is nudged by one step toward its target point, so the bit instant follows the sender's timing.

When the phase counter completes a bit period, the block decides the line bit by majority vote over the five newest samples. It then decodes that line bit as NRZI against the previous line bit. It emits one data bit with a one-clock strobe. A downstream deframer consumes the bit/strobe pair.

The nudge selector is a three-state choice made on every accepted sample. HOLD applies when no transition is seen. UP applies when a transition is seen and the phase is below 16; it adds one step. DOWN applies when a transition is seen and the phase is 16 or more; it subtracts one step. Every sample goes from the previous choice straight to any of the three; there is no memory between samples.

Top module: `afsk_bitclk_recover`

## Requirements
- R1: A synchronous reset clears the phase counter to 0, the sample history to all zeros and the previous line bit to 0, and holds `bit_stb` and `bit_out` low.
- R2: Each accepted sample adds 8 to the phase (0..63). When the sum reaches 64 or more, 64 is subtracted and the remainder is kept. That sample is a bit instant. With no transitions, bit instants fall on every 8th accepted sample, counting from reset.
- R3: The history shifts each accepted tone bit in at bit 0. A transition is seen when history bits [1:0] both differ from bits [3:2], with the new sample already included. A single odd sample never counts as a transition.
- R4: On a transition the phase moves one step before the wrap test of the same sample: +1 if the phase was below 16, otherwise -1.
- R5: At a bit instant the line bit is 1 when three or more of the five newest samples, the current one included, are 1. Otherwise it is 0.
- R6: The data bit is 1 when the line bit equals the previous line bit and 0 when they differ. The line bit then becomes the previous line bit.
- R7: `bit_stb` is high for exactly one clock, in the cycle after the clock edge that accepts the bit-instant sample, with `bit_out` valid in that cycle.
- R8: Cycles with `smp_valid` low change neither phase nor history nor the previous line bit, whatever `smp_tone` does.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_valid | input | 1 | One accepted sample this cycle |
| smp_tone | input | 1 | Hard-decision tone bit of the sample |
| bit_out | output | 1 | Decoded data bit |
| bit_stb | output | 1 | One-clock strobe for `bit_out` |

## Verification
The assertions take for granted that `smp_valid` marks isolated samples at a rate where at least seven samples separate bit instants. The phase step of 8 against a nudge of 1 makes that hold for any input. They also take for granted that `smp_tone` is only meaningful in cycles with `smp_valid` high. The stimulus drives each sample for one cycle with an idle cycle between. It deliberately toggles `smp_tone` while `smp_valid` is low to show it is ignored. It keeps every run of samples short enough that the 1-step nudges never wrap the phase outside its 0..63 range.

// File: rtl/afsk_rx_pkg.sv
package afsk_rx_pkg;

    typedef enum logic [1:0] {
        NUDGE_HOLD = 2'd0,
        NUDGE_UP   = 2'd1,
        NUDGE_DOWN = 2'd2
    } nudge_e;

endpackage

// File: rtl/tone_history.sv
module tone_history #(
    parameter int VOTE_N = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              smp_valid,
    input  logic              smp_tone,
    output logic [VOTE_N-1:0] window,
    output logic              edge_seen
);
    localparam int HIST_W = (VOTE_N > 4) ? VOTE_N : 4;

    logic [HIST_W-2:0] hist_q;
    logic [HIST_W-1:0] hist_next;

    // newest sample enters at bit 0
    assign hist_next = {hist_q, smp_tone};

    always_ff @(posedge clk) begin
        if (rst) begin
            hist_q <= '0;
        end else if (smp_valid) begin
            hist_q <= hist_next[HIST_W-2:0];
        end
    end

    // pair-wise disagreement: a lone odd sample cannot satisfy both bits
    assign edge_seen = smp_valid && ((hist_next[1:0] ^ hist_next[3:2]) == 2'b11);
    assign window    = hist_next[VOTE_N-1:0];

    assert_hist_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !smp_valid |=> $stable(hist_q));

    assert_hist_shift_R3: assert property (@(posedge clk) disable iff (rst)
        smp_valid |=> hist_q[0] == $past(smp_tone));

endmodule

// File: rtl/phase_tracker.sv
module phase_tracker
    import afsk_rx_pkg::*;
#(
    parameter int SAMPLES_PER_BIT = 8,
    parameter int PHASE_STEPS     = 8,
    parameter int NUDGE           = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic smp_valid,
    input  logic edge_seen,
    output logic wrap
);
    localparam int PH_MAX = SAMPLES_PER_BIT * PHASE_STEPS;
    localparam int PH_THR = PH_MAX / 4;
    localparam int PH_W   = $clog2(PH_MAX);
    localparam int SUM_W  = PH_W + 2;

    logic [PH_W-1:0]  phase_q;
    logic [PH_W-1:0]  phase_d;
    logic [SUM_W-1:0] base;
    logic [SUM_W-1:0] sum;
    nudge_e           nudge;

    // choice of nudge for this sample
    always_comb begin
        if (!edge_seen) begin
            nudge = NUDGE_HOLD;
        end else if (phase_q < PH_W'(PH_THR)) begin
            nudge = NUDGE_UP;
        end else begin
            nudge = NUDGE_DOWN;
        end
    end

    // nudge is applied before the wrap test
    always_comb begin
        base = SUM_W'(phase_q) + SUM_W'(PHASE_STEPS);
        unique case (nudge)
            NUDGE_HOLD: sum = base;
            NUDGE_UP:   sum = base + SUM_W'(NUDGE);
            NUDGE_DOWN: sum = base - SUM_W'(NUDGE);
            default:    sum = base;
        endcase
    end

    assign wrap    = smp_valid && (sum >= SUM_W'(PH_MAX));
    assign phase_d = wrap ? PH_W'(sum - SUM_W'(PH_MAX)) : PH_W'(sum);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= '0;
        end else if (smp_valid) begin
            phase_q <= phase_d;
        end
    end

    assert_phase_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !smp_valid |=> $stable(phase_q));

    assert_phase_step_R4: assert property (@(posedge clk) disable iff (rst)
        (smp_valid && !wrap) |=>
            (int'(phase_q) >= int'($past(phase_q)) + PHASE_STEPS - NUDGE) &&
            (int'(phase_q) <= int'($past(phase_q)) + PHASE_STEPS + NUDGE));

    assert_wrap_residue_R2: assert property (@(posedge clk) disable iff (rst)
        wrap |=> int'(phase_q) < PHASE_STEPS + NUDGE);

    assert_hold_steady_R4: assert property (@(posedge clk) disable iff (rst)
        (smp_valid && !edge_seen && !wrap) |=>
            int'(phase_q) == int'($past(phase_q)) + PHASE_STEPS);

endmodule

// File: rtl/bit_decider.sv
module bit_decider #(
    parameter int VOTE_N   = 5,
    parameter int VOTE_MIN = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wrap,
    input  logic [VOTE_N-1:0] window,
    output logic              bit_out,
    output logic              bit_stb
);
    localparam int CNT_W = $clog2(VOTE_N + 1);

    logic [CNT_W-1:0] ones;
    logic             line_bit;
    logic             prev_q;
    logic             data_q;
    logic             stb_q;

    always_comb begin
        ones = '0;
        for (int i = 0; i < VOTE_N; i++) begin
            ones = ones + CNT_W'(window[i]);
        end
    end

    assign line_bit = (ones >= CNT_W'(VOTE_MIN));

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= 1'b0;
            data_q <= 1'b0;
            stb_q  <= 1'b0;
        end else begin
            stb_q <= wrap;
            if (wrap) begin
                data_q <= ~(line_bit ^ prev_q);
                prev_q <= line_bit;
            end
        end
    end

    assign bit_out = data_q;
    assign bit_stb = stb_q;

    assert_stb_single_R7: assert property (@(posedge clk) disable iff (rst)
        bit_stb |=> !bit_stb);

    assert_prev_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !wrap |=> $stable(prev_q));

endmodule

// File: rtl/afsk_bitclk_recover.sv
module afsk_bitclk_recover #(
    parameter int SAMPLES_PER_BIT = 8,
    parameter int PHASE_STEPS     = 8,
    parameter int NUDGE           = 1,
    parameter int VOTE_N          = 5,
    parameter int VOTE_MIN        = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic smp_valid,
    input  logic smp_tone,
    output logic bit_out,
    output logic bit_stb
);
    logic [VOTE_N-1:0] window;
    logic              edge_seen;
    logic              wrap;

    tone_history #(.VOTE_N(VOTE_N)) u_hist (
        .clk       (clk),
        .rst       (rst),
        .smp_valid (smp_valid),
        .smp_tone  (smp_tone),
        .window    (window),
        .edge_seen (edge_seen)
    );

    phase_tracker #(
        .SAMPLES_PER_BIT (SAMPLES_PER_BIT),
        .PHASE_STEPS     (PHASE_STEPS),
        .NUDGE           (NUDGE)
    ) u_phase (
        .clk       (clk),
        .rst       (rst),
        .smp_valid (smp_valid),
        .edge_seen (edge_seen),
        .wrap      (wrap)
    );

    bit_decider #(
        .VOTE_N   (VOTE_N),
        .VOTE_MIN (VOTE_MIN)
    ) u_dec (
        .clk     (clk),
        .rst     (rst),
        .wrap    (wrap),
        .window  (window),
        .bit_out (bit_out),
        .bit_stb (bit_stb)
    );

    assert_stb_from_sample_R7: assert property (@(posedge clk) disable iff (rst)
        bit_stb |-> $past(smp_valid));

    assert_reset_quiet_R1: assert property (@(posedge clk)
        $past(rst) |-> !bit_stb);

endmodule

// File: tb/test_afsk_bitclk_recover.sv
module test_afsk_bitclk_recover;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic smp_valid = 1'b0;
    logic smp_tone = 1'b0;
    logic bit_out;
    logic bit_stb;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // reference state, built from the requirements
    logic [4:0] m_hist;
    int         m_phase;
    logic       m_prev;

    always #2 clk = ~clk;

    afsk_bitclk_recover i_afsk_bitclk_recover (
        .clk       (clk),
        .rst       (rst),
        .smp_valid (smp_valid),
        .smp_tone  (smp_tone),
        .bit_out   (bit_out),
        .bit_stb   (bit_stb)
    );

    localparam logic [31:0] PATS [6] = '{
        32'h0000_0000, 32'hFFFF_FFFF, 32'h00FF_00FF,
        32'h0F0F_F0F0, 32'hFF00_0FF0, 32'h3C3C_C3C3
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; smp_valid = 1'b0; smp_tone = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_hist = '0; m_phase = 0; m_prev = 1'b0;
    endtask

    // one accepted sample; returns what the ports show afterwards
    task automatic put(input logic b, output logic s, output logic d,
                       output logic es, output logic ed);
        logic [4:0] h;
        bit tr;
        int p;
        logic line;
        @(negedge clk);
        smp_valid = 1'b1; smp_tone = b;
        @(negedge clk);
        smp_valid = 1'b0;
        s = bit_stb; d = bit_out;
        h = {m_hist[3:0], b};
        tr = ((h[1:0] ^ h[3:2]) == 2'b11);
        p = m_phase + 8;
        if (tr) p = (m_phase < 16) ? p + 1 : p - 1;
        es = (p >= 64);
        if (es) p = p - 64;
        line = ($countones(h) >= 3);
        ed = 1'b0;
        if (es) begin
            ed = (line == m_prev);
            m_prev = line;
        end
        m_hist = h; m_phase = p;
    endtask

    // compare one sample against the reference model
    task automatic put_cmp(input logic b, input string req);
        logic s, d, es, ed;
        put(b, s, d, es, ed);
        check(s == es, req, s, es);
        if (es) check(d == ed, req, d, ed);
    endtask

    // directed sequence with hand-derived strobe position and bit
    task automatic seq_expect(input logic [15:0] seq, input int n, input int at,
                              input logic exp_bit, input string req);
        logic s, d, es, ed;
        do_reset();
        for (int i = 0; i < n; i++) begin
            put(seq[i], s, d, es, ed);
            check(s == (i + 1 == at), req, s, (i + 1 == at));
            if (i + 1 == at) check(d == exp_bit, req, d, exp_bit);
        end
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic s, d, es, ed;

        // R1: reset state
        do_reset();
        check(bit_stb == 1'b0, "R1 stb after reset", bit_stb, 0);
        check(bit_out == 1'b0, "R1 bit after reset", bit_out, 0);

        // table walk against the reference model
        foreach (PATS[k]) begin
            do_reset();
            for (int i = 0; i < 32; i++) put_cmp(PATS[k][i], "R2 R5 R6 table");
        end

        // drifting sender: 9-sample then 7-sample symbols
        do_reset();
        for (int sym = 0; sym < 24; sym++) begin
            int len = (sym < 12) ? 9 : 7;
            for (int j = 0; j < len; j++) put_cmp(sym[0] ^ sym[2], "R4 drift");
        end

        // R2 R6: idle zeros give a strobe on the 8th sample, data 1
        seq_expect(16'h0000, 8, 8, 1'b1, "R2 R6 zeros");
        // R7: strobe lasts one clock
        @(negedge clk);
        check(bit_stb == 1'b0, "R7 single clock strobe", bit_stb, 0);

        // R3 R4: late transition at phase 56 pulls the instant to sample 9
        seq_expect(16'h01C0, 9, 9, 1'b0, "R4 down nudge");
        // R4: early transition adds a step so a later down nudge wraps on time
        seq_expect(16'h003F, 8, 8, 1'b0, "R4 up nudge");
        // R3: single glitch sample does not move the instant
        seq_expect(16'h0040, 8, 8, 1'b1, "R3 glitch rejected");
        // R5: two of five ones -> line 0 -> data 1
        seq_expect(16'h0050, 8, 8, 1'b1, "R5 vote two");
        // R5: three of five ones -> line 1 -> data 0
        seq_expect(16'h00A8, 8, 8, 1'b0, "R5 vote three");

        // R6: constant ones decode 0 then 1
        do_reset();
        for (int i = 1; i <= 16; i++) begin
            put(1'b1, s, d, es, ed);
            if (i == 8)  check(s && d == 1'b0, "R6 first bit", {s, d}, 2);
            if (i == 16) check(s && d == 1'b1, "R6 second bit", {s, d}, 3);
        end

        // R1: reset clears previous line bit (it was 1 here)
        seq_expect(16'h0000, 8, 8, 1'b1, "R1 prev cleared");

        // R8: tone toggles with valid low are ignored
        do_reset();
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            smp_tone = i[0];
            check(bit_stb == 1'b0, "R8 idle no strobe", bit_stb, 0);
        end
        smp_tone = 1'b1;
        @(negedge clk);
        for (int i = 1; i <= 8; i++) begin
            put(1'b0, s, d, es, ed);
            check(s == (i == 8), "R8 phase untouched", s, (i == 8));
            if (i == 8) check(d == 1'b1, "R8 history untouched", d, 1);
        end

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule